// File: doc/BRIEF.md
# Serial Receive Framer with Companding

This block is the receive half of a synchronous serial port. On every rising edge of the bit clock it looks at a frame-sync input and a serial data input. A frame-sync pulse starts a word. After a programmable delay of zero, one or two bit clocks, the block shifts in a programmable number of data bits. When the last bit arrives, it converts the word into the selected output format and loads it into a receive buffer register. At the same time it raises a ready flag, which stays up until the consumer pulses a read strobe.

A frame-sync pulse that arrives while a word is still being shifted in is treated as unexpected. One configuration bit selects how such a pulse is handled. In the first policy the partial word is discarded, a sticky error flag is raised and a fresh word is started. In the second policy the pulse is ignored and the current word runs to completion. A pulse that arrives on the same edge as the final bit of a word is a legal back-to-back frame and is not an error.

A two-bit format field selects how 8-bit words are presented: plain, bit-reversed, or expanded from one of two logarithmic telephone codes. For every other word length the field is disregarded.

Top module: `srx_framer`

## Requirements
- R1: After reset, rx_word is 0, rx_ready is 0 and sync_err is 0.
- R2: cfg_len_code selects the word length: 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and 5 to 7 give 32. Exactly that many bits are captured per frame, and a single word is delivered for each frame.
- R3: The first data bit is sampled cfg_delay bit clocks after the edge on which frame sync is seen, where cfg_delay is 0, 1 or 2 (a value of 3 acts as 2). The remaining bits are sampled on consecutive edges after it. The word appears on rx_word, with rx_ready high, in the cycle after the edge that samples its last bit.
- R4: With cfg_fmt = 0, the first received bit is the most significant bit. The word is right-justified in rx_word and its upper bits are zero.
- R5: With cfg_fmt = 1 and an 8-bit length, the first received bit is bit 0. rx_word[7:0] carries the byte in its true order and the upper bits are zero.
- R6: With cfg_fmt = 2 and an 8-bit length, the received byte is decoded as mu-law and output as a 16-bit left-justified two's-complement value, sign-extended to 32 bits. The decoding inverts all bits; the sign is bit 7 of the inverted byte, the exponent is bits 6:4 and the mantissa is bits 3:0. The magnitude is 4*(((2*m+33)<<e)-33), and it is negated when the sign is 1.
- R7: With cfg_fmt = 3 and an 8-bit length, the received byte is decoded as A-law and output in the same 16-bit form as R6. The decoding XORs the byte with 0x55; the sign is bit 7, the segment is bits 6:4 and the mantissa is bits 3:0. The magnitude is 16*m+8 when the segment is 0 and 8*((2*m+33)<<(s-1)) otherwise. The result is positive when the sign is 1.
- R8: When cfg_len_code is not 0, cfg_fmt values 1, 2 and 3 behave exactly as value 0.
- R9: With cfg_fs_ignore = 0, a frame-sync pulse seen while a word is incomplete has three effects: the partial word is discarded and never delivered, sync_err is set, and a new word starts whose first bit follows the delay of R3 counted from that pulse. A pulse on the edge that samples a word's last bit is not unexpected.
- R10: With cfg_fs_ignore = 1, a frame-sync pulse seen while a word is incomplete has no effect. The word completes and is delivered as if no pulse had occurred, and sync_err stays 0.
- R11: sync_err stays 1 until err_clr is pulsed. A new error on the same edge as a clear wins.
- R12: rx_ready stays 1 and rx_word holds its value until rd_strobe is seen. rx_ready then drops on the next edge unless a new word is delivered on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_in | input | 1 | Frame-sync pulse |
| sd_in | input | 1 | Serial data |
| cfg_len_code | input | 3 | Word-length code |
| cfg_delay | input | 2 | Data delay in bit clocks |
| cfg_fmt | input | 2 | Output format select |
| cfg_fs_ignore | input | 1 | 1 = ignore unexpected frame sync, 0 = abort and restart |
| rd_strobe | input | 1 | Buffer read; clears rx_ready |
| err_clr | input | 1 | Clears sync_err |
| rx_word | output | 32 | Receive buffer register |
| rx_ready | output | 1 | A word is waiting in rx_word |
| sync_err | output | 1 | Sticky unexpected-frame-sync flag |

## Verification
Every combination of length code and data delay carries a fixed bit pattern. This distinguishes a bit counter or delay counter that is off by one, and shows whether the first bit lands in the top position or the bottom one. All 256 byte codes are swept through the reversed, mu-law and A-law formats, with expected values computed arithmetically, so every segment and sign is covered, along with both zero codes. A 12-bit word in each non-plain format shows that the format field is disregarded for lengths other than 8. One fixed stream with a second frame-sync pulse in mid-word is replayed under both policies and all three delays. The first policy must deliver the bits that follow the pulse and the second must deliver the original word. A back-to-back stream with the pulse on the last-bit edge must yield two words and no error.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    FMT_MSB   = 2'd0,
    FMT_LSB8  = 2'd1,
    FMT_MULAW = 2'd2,
    FMT_ALAW  = 2'd3
  } srx_fmt_e;

  // Word length in bits for a length code.
  function automatic int unsigned len_of(input logic [2:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 12;
      3'd2:    return 16;
      3'd3:    return 20;
      3'd4:    return 24;
      default: return 32;
    endcase
  endfunction

  // Logarithmic mu-law byte to 16-bit linear sample.
  function automatic logic [15:0] mulaw_expand(input logic [7:0] code);
    logic [7:0]  inv;
    logic [15:0] mag;
    inv = ~code;
    mag = ((16'(inv[3:0]) << 3) + 16'd132) << inv[6:4];
    mag = mag - 16'd132;
    return inv[7] ? -mag : mag;
  endfunction

  // Logarithmic A-law byte to 16-bit linear sample.
  function automatic logic [15:0] alaw_expand(input logic [7:0] code);
    logic [7:0]  tog;
    logic [15:0] mag;
    tog = code ^ 8'h55;
    mag = 16'(tog[3:0]) << 4;
    if (tog[6:4] == 3'd0) mag = mag + 16'd8;
    else                  mag = (mag + 16'h0108) << (tog[6:4] - 3'd1);
    return tog[7] ? mag : -mag;
  endfunction

endpackage

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_in,
  input  logic              sd_in,
  input  logic [2:0]        len_code,
  input  logic [1:0]        delay,
  input  logic              fs_ignore,
  output logic              deliver,
  output logic              abort,
  output logic [DATA_W-1:0] raw
);

  logic              busy_q, busy_d;
  logic [1:0]        wait_q, wait_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  len_w;
  logic [1:0]        delay_c;
  logic              done_now, start;

  assign len_w   = CNT_W'(srx_pkg::len_of(len_code));
  assign delay_c = (delay == 2'd3) ? 2'd2 : delay;

  always_comb begin
    done_now = busy_q && (wait_q == 2'd0) && (cnt_q == len_w - CNT_W'(1));
    start    = fs_in && (!busy_q || done_now || !fs_ignore);
    abort    = fs_in && busy_q && !done_now && !fs_ignore;
    deliver  = done_now;
    raw      = {sh_q[DATA_W-2:0], sd_in};

    busy_d = busy_q;
    wait_d = wait_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    if (start) begin
      busy_d = 1'b1;
      wait_d = delay_c;
      cnt_d  = '0;
      sh_d   = '0;
    end else if (done_now) begin
      busy_d = 1'b0;
    end
    // one wait or one sample per edge for the active word
    if (busy_d) begin
      if (wait_d != 2'd0) begin
        wait_d = wait_d - 2'd1;
      end else begin
        sh_d  = {sh_d[DATA_W-2:0], sd_in};
        cnt_d = cnt_d + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wait_q <= 2'd0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      wait_q <= wait_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
    end
  end

  a_r3_wait_range: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q <= 2'd2);

  a_r10_ignore_keeps_counting: assert property (@(posedge clk) disable iff (!rst_n)
    fs_ignore && fs_in && busy_q && !done_now && (wait_q == 2'd0)
    |=> cnt_q == $past(cnt_q) + CNT_W'(1));

endmodule

// File: rtl/srx_format.sv
module srx_format #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [1:0]        fmt,
  input  logic [2:0]        len_code,
  output logic [DATA_W-1:0] word
);

  logic [7:0]  rev;
  logic [15:0] lin;

  always_comb begin
    for (int i = 0; i < 8; i++) rev[i] = raw[7 - i];
    lin  = '0;
    word = raw;
    if (len_code == 3'd0) begin
      case (srx_pkg::srx_fmt_e'(fmt))
        srx_pkg::FMT_LSB8: word = {{(DATA_W-8){1'b0}}, rev};
        srx_pkg::FMT_MULAW: begin
          lin  = srx_pkg::mulaw_expand(raw[7:0]);
          word = {{(DATA_W-16){lin[15]}}, lin};
        end
        srx_pkg::FMT_ALAW: begin
          lin  = srx_pkg::alaw_expand(raw[7:0]);
          word = {{(DATA_W-16){lin[15]}}, lin};
        end
        default: word = raw;
      endcase
    end
  end

endmodule

// File: rtl/srx_framer.sv
module srx_framer #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_in,
  input  logic              sd_in,
  input  logic [2:0]        cfg_len_code,
  input  logic [1:0]        cfg_delay,
  input  logic [1:0]        cfg_fmt,
  input  logic              cfg_fs_ignore,
  input  logic              rd_strobe,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_ready,
  output logic              sync_err
);

  logic              deliver, abort;
  logic [DATA_W-1:0] raw, fmt_word;
  logic              ready_d, err_d;

  srx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_in     (fs_in),
    .sd_in     (sd_in),
    .len_code  (cfg_len_code),
    .delay     (cfg_delay),
    .fs_ignore (cfg_fs_ignore),
    .deliver   (deliver),
    .abort     (abort),
    .raw       (raw)
  );

  srx_format #(.DATA_W(DATA_W)) u_format (
    .raw      (raw),
    .fmt      (cfg_fmt),
    .len_code (cfg_len_code),
    .word     (fmt_word)
  );

  always_comb begin
    ready_d = rx_ready;
    if (rd_strobe) ready_d = 1'b0;
    if (deliver)   ready_d = 1'b1;
    err_d = sync_err;
    if (err_clr) err_d = 1'b0;
    if (abort)   err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word  <= '0;
      rx_ready <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      if (deliver) rx_word <= fmt_word;
      rx_ready <= ready_d;
      sync_err <= err_d;
    end
  end

  a_r9_abort_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> sync_err);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err && !err_clr |=> sync_err);

  a_r12_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && rd_strobe && !deliver |=> !rx_ready);

  a_r12_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !deliver |=> $stable(rx_word));

endmodule

// File: tb/srx_framer_tb.sv
module srx_framer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, fs, sd, rd, eclr, ign;
  logic [2:0]  lcode;
  logic [1:0]  dly, fmt;
  logic [31:0] rx_word;
  logic        rx_ready, sync_err;

  int errors = 0;
  int checks = 0;
  logic [31:0] got [4];
  int ngot;
  bit auto_rd = 1'b1;

  srx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .fs_in(fs), .sd_in(sd),
    .cfg_len_code(lcode), .cfg_delay(dly), .cfg_fmt(fmt),
    .cfg_fs_ignore(ign), .rd_strobe(rd), .err_clr(eclr),
    .rx_word(rx_word), .rx_ready(rx_ready), .sync_err(sync_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int len_bits(input int code);
    case (code)
      0: return 8;  1: return 12; 2: return 16;
      3: return 20; 4: return 24; default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] exp_mu(input int c);
    int u, e, m, mag;
    u = 255 - c;
    e = (u / 16) % 8;
    m = u % 16;
    mag = (((2*m + 33) << e) - 33) * 4;
    return 32'((u >= 128) ? -mag : mag);
  endfunction

  function automatic logic [31:0] exp_a(input int c);
    int a, s, m, mag;
    a = c ^ 85;
    s = (a / 16) % 8;
    m = a % 16;
    mag = (s == 0) ? (16*m + 8) : (((2*m + 33) << (s - 1)) * 8);
    return 32'((a >= 128) ? mag : -mag);
  endfunction

  function automatic logic [31:0] grab(input logic [127:0] p, input int s, input int n);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < n; k++) r = {r[30:0], p[s + k]};
    return r;
  endfunction

  // Replay a frame-sync / data stream; words are collected through the read strobe.
  task automatic run(input logic [127:0] fsp, input logic [127:0] dp, input int n);
    ngot = 0;
    for (int j = 0; j < n + 3; j++) begin
      @(negedge clk);
      rd = 1'b0;
      if (rx_ready && auto_rd) begin
        if (ngot < 4) got[ngot] = rx_word;
        ngot++;
        rd = 1'b1;
      end
      fs = (j < n) ? fsp[j] : 1'b0;
      sd = (j < n) ? dp[j] : 1'b0;
    end
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int len, input int d, input bit lsb_first);
    logic [127:0] fp, dp;
    fp = '0; dp = '0;
    fp[0] = 1'b1;
    for (int k = 0; k < len; k++) dp[d + k] = lsb_first ? v[k] : v[len - 1 - k];
    run(fp, dp, d + len);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, e;
    logic [127:0] fp, dp;
    rst_n = 1'b0; fs = 0; sd = 0; rd = 0; eclr = 0; ign = 0;
    lcode = 0; dly = 0; fmt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_word == 0, "R1 word", rx_word, 0);
    chk(!rx_ready, "R1 ready", 32'(rx_ready), 0);
    chk(!sync_err, "R1 err", 32'(sync_err), 0);

    // R2 R3 R4: all lengths, all delays, plain format
    for (int c = 0; c < 8; c++) begin
      for (int d = 0; d < 4; d++) begin
        lcode = 3'(c); dly = 2'(d); fmt = 0;
        v = 32'hC5A3_96E1 ^ (32'(c) * 32'h0101_1011);
        if (len_bits(c) < 32) v = v & ((32'd1 << len_bits(c)) - 1);
        send(v, len_bits(c), (d == 3) ? 2 : d, 1'b0);
        chk(ngot == 1, "R2 word count", 32'(ngot), 1);
        chk(got[0] == v, "R3 R4 plain word", got[0], v);
      end
    end

    // R5 R6 R7: full byte sweeps
    lcode = 0;
    for (int f = 1; f < 4; f++) begin
      for (int c = 0; c < 256; c++) begin
        fmt = 2'(f); dly = 2'(c % 3);
        send(32'(c), 8, c % 3, f == 1);
        e = (f == 1) ? 32'(c) : ((f == 2) ? exp_mu(c) : exp_a(c));
        chk(ngot == 1 && got[0] == e, (f == 1) ? "R5 reversed" : ((f == 2) ? "R6 mulaw" : "R7 alaw"), got[0], e);
      end
    end

    // R8: non-8-bit lengths disregard the format field
    lcode = 1; dly = 1;
    for (int f = 1; f < 4; f++) begin
      fmt = 2'(f);
      send(32'h0000_0A5C, 12, 1, 1'b0);
      chk(got[0] == 32'h0000_0A5C, "R8 plain at 12 bits", got[0], 32'h0000_0A5C);
    end

    // R9 R10 R11: unexpected frame sync at cycle 5
    lcode = 0; fmt = 0;
    dp = 128'h3E5B_D197_0C6A_F248_9B1E_57C3_A4D0_6F2B;
    for (int d = 0; d < 3; d++) begin
      dly = 2'(d);
      fp = '0; fp[0] = 1'b1; fp[5] = 1'b1;
      ign = 1'b1;
      run(fp, dp, d + 20);
      e = grab(dp, d, 8);
      chk(ngot == 1 && got[0] == e, "R10 ignored pulse", got[0], e);
      chk(!sync_err, "R10 no error", 32'(sync_err), 0);
      ign = 1'b0;
      run(fp, dp, d + 20);
      e = grab(dp, 5 + d, 8);
      chk(ngot == 1 && got[0] == e, "R9 restart word", got[0], e);
      chk(sync_err, "R9 error set", 32'(sync_err), 1);
      repeat (4) @(negedge clk);
      chk(sync_err, "R11 error held", 32'(sync_err), 1);
      eclr = 1'b1;
      @(negedge clk);
      eclr = 1'b0;
      chk(!sync_err, "R11 error cleared", 32'(sync_err), 0);
    end

    // R9: pulse on the last-bit edge is a legal back-to-back frame
    for (int d = 1; d < 3; d++) begin
      dly = 2'(d);
      fp = '0; fp[0] = 1'b1; fp[d + 7] = 1'b1;
      run(fp, dp, 2*d + 16);
      chk(ngot == 2, "R9 back-to-back count", 32'(ngot), 2);
      chk(got[0] == grab(dp, d, 8) && got[1] == grab(dp, 2*d + 7, 8), "R9 back-to-back words", got[1], grab(dp, 2*d + 7, 8));
      chk(!sync_err, "R9 back-to-back no error", 32'(sync_err), 0);
    end

    // R12: ready and word held until read
    auto_rd = 1'b0; dly = 0; fmt = 0;
    send(32'h0000_00D2, 8, 0, 1'b0);
    repeat (3) @(negedge clk);
    chk(rx_ready, "R12 ready held", 32'(rx_ready), 1);
    chk(rx_word == 32'hD2, "R12 word held", rx_word, 32'hD2);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(!rx_ready, "R12 ready cleared", 32'(rx_ready), 0);
    chk(rx_word == 32'hD2, "R12 word after read", rx_word, 32'hD2);
    auto_rd = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule